// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs single read or write transfers from a processor core onto an external asynchronous memory bus. The core raises a request with an address, a direction flag, a write word, a set of attribute-line selects and a DRAM-type flag, and holds it until a one-clock ready pulse comes back. While a transfer is open the block holds the address and write word steady, pulls the matching active-low strobe low, and drives the attribute lines, which serve as chip selects or extra address bits, at a polarity set per line by configuration.

The length of a transfer is one base clock plus a number of wait clocks. That number is the larger of two values: the minimum count latched from a configuration input when the transfer starts, and the time until the external active-low acknowledge is seen. The acknowledge is used only when the minimum count is nonzero and the access is not DRAM-type. It has no effect while the bus is idle. A mode input chooses whether the acknowledge passes through a two-flop synchroniser or is sampled directly. During reset and standby an output-enable drops low so that the pads tri-state the strobes and attribute lines. No new transfer starts in standby.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: While `rst` or `standby` is high, `bus_ctl_oe` is 0. After reset both strobes are high and `core_ready` is 0.
- R2: A read drives `bus_rd_n` low and keeps `bus_wr_n` high with `bus_wdata_oe` 0. A write drives `bus_wr_n` low and keeps `bus_rd_n` high with `bus_wdata_oe` 1 and `bus_wdata` equal to the requested word. The two strobes are never low together.
- R3: When the acknowledge is seen no later than the minimum count requires, the strobe stays low for exactly W+1 clocks, where W is `cfg_min_wait`.
- R4: In direct mode (`cfg_ack_async`=0), with W≥1 and `bus_ta_n` first low at the clock edge that ends strobe clock j (the first strobe clock is j=0), the strobe lasts max(W, j+1)+1 clocks.
- R5: In synchronised mode (`cfg_ack_async`=1), the same case takes max(W, j+3)+1 clocks.
- R6: With W=0 the strobe lasts exactly one clock, even if the acknowledge is never asserted.
- R7: A DRAM-type access (`core_dram`=1) lasts W+1 clocks, even if the acknowledge is never asserted.
- R8: An acknowledge asserted and released while the bus is idle does not shorten the next transfer.
- R9: Attribute line i reads `cfg_attr_pol[i]` while its select is set during a transfer, and reads the inverse of `cfg_attr_pol[i]` otherwise, including when the bus is idle.
- R10: `core_ready` is high for exactly one clock, in the clock that follows the last strobe clock. On a read, `core_rdata` then holds the `bus_rdata` value present in the last strobe clock.
- R11: `bus_addr` stays at the requested address for the whole transfer, even if `core_addr` changes after acceptance.
- R12: A request that arrives while `standby` is high does not start until `standby` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Low-power standby: pins tri-stated, no new transfers |
| cfg_min_wait | input | WAIT_W | Minimum wait clocks, latched when a transfer starts |
| cfg_ack_async | input | 1 | 1: acknowledge passes through the synchroniser; 0: sampled directly |
| cfg_attr_pol | input | ATTR_N | Per-line attribute polarity, 1 = active-high |
| core_req | input | 1 | Transfer request, held until ready |
| core_we | input | 1 | 1 = write, 0 = read |
| core_dram | input | 1 | DRAM-type access: acknowledge ignored |
| core_addr | input | ADDR_W | Transfer address |
| core_wdata | input | DATA_W | Write word |
| core_attr_sel | input | ATTR_N | Attribute lines to assert for this transfer |
| core_ready | output | 1 | One-clock completion pulse |
| core_rdata | output | DATA_W | Read word captured at completion |
| bus_addr | output | ADDR_W | External address, held through the transfer |
| bus_wdata | output | DATA_W | External write word |
| bus_wdata_oe | output | 1 | Data-bus drive enable, writes only |
| bus_rdata | input | DATA_W | External read word |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_attr | output | ATTR_N | Attribute / chip-select lines |
| bus_ctl_oe | output | 1 | Pad enable for strobes and attribute lines |
| bus_ta_n | input | 1 | Active-low transfer acknowledge |

## Verification
A wait counter or acknowledge flag with the wrong value shows up as a strobe that is too short or too long. The bench measures that length in whole clocks for every transfer, so the error is caught at the ready pulse of the transfer it affects. A latched register that goes stale shows up on every strobe clock as a mismatch in address, direction, write word or attribute level. A stale acknowledge that leaks across transfers shows up on the next transfer as a strobe that ends too early. The idle-acknowledge and synchronised-mode cases are set up to expose exactly that.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        XB_IDLE   = 2'd0,
        XB_ACTIVE = 2'd1,
        XB_DONE   = 2'd2
    } xb_state_e;

    // Per-transfer control captured at acceptance
    typedef struct packed {
        logic we;
        logic dram;
    } xb_ctl_t;

    // Level of one attribute line: polarity when asserted, inverse otherwise
    function automatic logic attr_level(input logic asserted, input logic pol);
        return asserted ? pol : ~pol;
    endfunction

    // The acknowledge may stretch a transfer only with a nonzero minimum
    // count and for non-DRAM accesses
    function automatic logic ack_allowed(input logic min_nonzero, input logic dram);
        return min_nonzero && !dram;
    endfunction

endpackage

// File: rtl/xbus_ack_sync.sv
module xbus_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ta_n,
    input  logic async_sel,
    output logic ack
);
    localparam int LAST = STAGES - 1;

    logic             ack_raw;
    logic [LAST:0]    chain;

    assign ack_raw = ~ta_n;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= ack_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign ack = async_sel ? chain[LAST] : ack_raw;

endmodule

// File: rtl/xbus_wait_timer.sv
module xbus_wait_timer #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              run,
    input  logic [WAIT_W-1:0] min_wait,
    input  logic              dram,
    input  logic              ack,
    output logic              done
);
    import xbus_pkg::*;

    localparam logic [WAIT_W-1:0] CNT_MAX = {WAIT_W{1'b1}};

    logic [WAIT_W-1:0] cnt_q;
    logic [WAIT_W-1:0] min_q;
    logic              use_ack_q;
    logic              seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            min_q     <= '0;
            use_ack_q <= 1'b0;
            seen_q    <= 1'b0;
        end else if (start) begin
            cnt_q     <= '0;
            min_q     <= min_wait;
            use_ack_q <= ack_allowed(min_wait != '0, dram);
            seen_q    <= 1'b0;
        end else if (run) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            if (ack)              seen_q <= 1'b1;
        end else begin
            seen_q <= 1'b0;
        end
    end

    assign done = run && (cnt_q >= min_q) && (!use_ack_q || seen_q);

endmodule

// File: rtl/xbus_pin_drv.sv
module xbus_pin_drv #(
    parameter int ATTR_N = 2
) (
    input  logic              rst,
    input  logic              standby,
    input  logic              active,
    input  logic              we,
    input  logic [ATTR_N-1:0] sel,
    input  logic [ATTR_N-1:0] pol,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ATTR_N-1:0] attr,
    output logic              ctl_oe
);
    import xbus_pkg::*;

    assign rd_n   = ~(active && !we);
    assign wr_n   = ~(active && we);
    assign ctl_oe = !rst && !standby;

    generate
        for (genvar g = 0; g < ATTR_N; g++) begin : g_attr
            assign attr[g] = attr_level(active && sel[g], pol[g]);
        end
    endgenerate

endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int WAIT_W      = 4,
    parameter int ATTR_N      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic [WAIT_W-1:0] cfg_min_wait,
    input  logic              cfg_ack_async,
    input  logic [ATTR_N-1:0] cfg_attr_pol,
    input  logic              core_req,
    input  logic              core_we,
    input  logic              core_dram,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic [ATTR_N-1:0] core_attr_sel,
    output logic              core_ready,
    output logic [DATA_W-1:0] core_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [ATTR_N-1:0] bus_attr,
    output logic              bus_ctl_oe,
    input  logic              bus_ta_n
);
    import xbus_pkg::*;

    xb_state_e         state_q;
    xb_ctl_t           ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [ATTR_N-1:0] sel_q;
    logic              accept;
    logic              active;
    logic              ack;
    logic              done;

    assign accept = (state_q == XB_IDLE) && core_req && !standby;
    assign active = (state_q == XB_ACTIVE);

    xbus_ack_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst       (rst),
        .ta_n      (bus_ta_n),
        .async_sel (cfg_ack_async),
        .ack       (ack)
    );

    xbus_wait_timer #(.WAIT_W(WAIT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .run      (active),
        .min_wait (cfg_min_wait),
        .dram     (core_dram),
        .ack      (ack),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XB_IDLE;
            ctl_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            sel_q   <= '0;
        end else begin
            unique case (state_q)
                XB_IDLE: begin
                    if (accept) begin
                        state_q    <= XB_ACTIVE;
                        ctl_q.we   <= core_we;
                        ctl_q.dram <= core_dram;
                        addr_q     <= core_addr;
                        wdata_q    <= core_wdata;
                        sel_q      <= core_attr_sel;
                    end
                end
                XB_ACTIVE: begin
                    if (done) begin
                        state_q <= XB_DONE;
                        if (!ctl_q.we) rdata_q <= bus_rdata;
                    end
                end
                default: state_q <= XB_IDLE;
            endcase
        end
    end

    xbus_pin_drv #(.ATTR_N(ATTR_N)) i_pins (
        .rst     (rst),
        .standby (standby),
        .active  (active),
        .we      (ctl_q.we),
        .sel     (sel_q),
        .pol     (cfg_attr_pol),
        .rd_n    (bus_rd_n),
        .wr_n    (bus_wr_n),
        .attr    (bus_attr),
        .ctl_oe  (bus_ctl_oe)
    );

    assign core_ready   = (state_q == XB_DONE);
    assign core_rdata   = rdata_q;
    assign bus_addr     = addr_q;
    assign bus_wdata    = wdata_q;
    assign bus_wdata_oe = active && ctl_q.we;

endmodule

// File: rtl/xbus_wait_ctrl_chk.sv
module xbus_wait_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              standby,
    input logic              core_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wdata_oe,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_ctl_oe
);
    logic strobe;
    assign strobe = !(bus_rd_n && bus_wr_n);

    // R1
    oe_low_in_reset_chk: assert property (@(posedge clk) rst |-> !bus_ctl_oe);

    // R1
    oe_low_in_standby_chk: assert property (@(posedge clk) standby |-> !bus_ctl_oe);

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_wr_n));

    // R2
    wdata_drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wdata_oe |-> !bus_wr_n);

    // R10
    ready_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        core_ready |=> !core_ready);

    // R10
    ready_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_ready) |-> $past(strobe));

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && $past(strobe)) |-> $stable(bus_addr));

    // R12
    no_start_in_standby_chk: assert property (@(posedge clk) disable iff (rst)
        (standby && !strobe) |=> !strobe);

endmodule

bind xbus_wait_ctrl xbus_wait_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .standby      (standby),
    .core_ready   (core_ready),
    .bus_addr     (bus_addr),
    .bus_wdata_oe (bus_wdata_oe),
    .bus_rd_n     (bus_rd_n),
    .bus_wr_n     (bus_wr_n),
    .bus_ctl_oe   (bus_ctl_oe)
);

// File: tb/test_xbus_wait_ctrl.sv
module test_xbus_wait_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        standby = 1'b0;
    logic [3:0]  cfg_min_wait = '0;
    logic        cfg_ack_async = 1'b0;
    logic [1:0]  cfg_attr_pol = 2'b01;
    logic        core_req = 1'b0;
    logic        core_we = 1'b0;
    logic        core_dram = 1'b0;
    logic [15:0] core_addr = '0;
    logic [15:0] core_wdata = '0;
    logic [1:0]  core_attr_sel = '0;
    logic        core_ready;
    logic [15:0] core_rdata;
    logic [15:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_wdata_oe;
    logic [15:0] bus_rdata;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic [1:0]  bus_attr;
    logic        bus_ctl_oe;
    logic        bus_ta_n = 1'b1;

    always #4 clk = ~clk;

    // Memory model: read word derived from the address
    assign bus_rdata = bus_addr ^ 16'h5A3C;

    xbus_wait_ctrl i_xbus_wait_ctrl (
        .clk(clk), .rst(rst), .standby(standby),
        .cfg_min_wait(cfg_min_wait), .cfg_ack_async(cfg_ack_async),
        .cfg_attr_pol(cfg_attr_pol), .core_req(core_req), .core_we(core_we),
        .core_dram(core_dram), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_attr_sel(core_attr_sel), .core_ready(core_ready),
        .core_rdata(core_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_attr(bus_attr),
        .bus_ctl_oe(bus_ctl_oe), .bus_ta_n(bus_ta_n)
    );

    typedef struct {
        bit          we;
        logic [15:0] addr;
        logic [15:0] data;
        logic [1:0]  attr;
        int          len;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   ack_at = -1;
    bit   force_ack = 0;
    bit   finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input int w, input int j, input bit async, input bit dram);
        int lat;
        if (w == 0 || dram) return w + 1;
        lat = async ? j + 3 : j + 1;
        return ((w > lat) ? w : lat) + 1;
    endfunction

    function automatic logic [1:0] attr_exp(input logic [1:0] sel, input logic [1:0] pol);
        return ~(sel ^ pol);
    endfunction

    // Monitor plus acknowledge responder, both at the falling edge
    int  mlen = 0;
    int  acnt = 0;
    bit  prev_act = 0;
    always @(negedge clk) begin
        bit act;
        act = !(bus_rd_n && bus_wr_n);
        if (!rst) begin
            if (act) begin
                if (!prev_act) mlen = 0;
                mlen++;
                if (q.size() > 0) begin
                    chk(bus_addr == q[0].addr, "R11", bus_addr, q[0].addr);
                    chk(bus_attr == q[0].attr, "R9", bus_attr, q[0].attr);
                    if (q[0].we)
                        chk(!bus_wr_n && bus_rd_n && bus_wdata_oe && bus_wdata == q[0].data,
                            "R2 write", {bus_wr_n, bus_rd_n, bus_wdata_oe, bus_wdata},
                            {1'b0, 1'b1, 1'b1, q[0].data});
                    else
                        chk(!bus_rd_n && bus_wr_n && !bus_wdata_oe, "R2 read",
                            {bus_rd_n, bus_wr_n, bus_wdata_oe}, 3'b010);
                end
            end else if (!standby && !core_ready) begin
                chk(bus_attr == ~cfg_attr_pol, "R9 idle", bus_attr, ~cfg_attr_pol);
            end
            if (core_ready) begin
                chk(prev_act && !act, "R10 ready timing", {prev_act, act}, 2'b10);
                if (q.size() == 0) begin
                    chk(0, "R10 unexpected ready", 0, 1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(mlen == e.len, e.tag, mlen, e.len);
                    if (!e.we)
                        chk(core_rdata == (e.addr ^ 16'h5A3C), "R10 rdata", core_rdata, e.addr ^ 16'h5A3C);
                end
            end
        end
        // responder
        if (!act) begin
            acnt = 0;
            bus_ta_n = force_ack ? 1'b0 : 1'b1;
        end else begin
            if (ack_at >= 0 && acnt >= ack_at) bus_ta_n = 1'b0;
            acnt++;
        end
        prev_act = act;
    end

    task automatic access(input bit we, input logic [15:0] addr, input logic [15:0] data,
                          input bit dram, input logic [1:0] sel, input int w, input int ackat,
                          input bit async, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_min_wait  = w[3:0];
        cfg_ack_async = async;
        core_we       = we;
        core_addr     = addr;
        core_wdata    = data;
        core_dram     = dram;
        core_attr_sel = sel;
        ack_at        = ackat;
        e.we = we; e.addr = addr; e.data = data;
        e.attr = attr_exp(sel, cfg_attr_pol);
        e.len = exp_len(w, ackat, async, dram);
        e.tag = tag;
        q.push_back(e);
        core_req = 1'b1;
        @(negedge clk);
        // R11: change the core-side address and data once the transfer is accepted
        core_addr  = ~addr;
        core_wdata = ~data;
        while (!core_ready) @(negedge clk);
        core_req = 1'b0;
        ack_at   = -1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_ctl_oe == 1'b0, "R1 oe in reset", bus_ctl_oe, 0);
        chk(bus_rd_n && bus_wr_n && !core_ready, "R1 reset state",
            {bus_rd_n, bus_wr_n, core_ready}, 3'b110);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_ctl_oe == 1'b1, "R1 oe after reset", bus_ctl_oe, 1);

        // R3: early acknowledge, minimum count rules
        access(0, 16'h0100, 16'h0, 0, 2'b01, 3, 0, 0, "R3 len read");
        access(1, 16'h0204, 16'hBEEF, 0, 2'b11, 2, 0, 0, "R3 len write");
        // R4: late acknowledge, direct mode
        access(0, 16'h0308, 16'h0, 0, 2'b10, 2, 5, 0, "R4 late ack");
        access(1, 16'h040C, 16'h1234, 0, 2'b01, 4, 1, 0, "R4 ack before min");
        // R5: synchronised mode
        access(0, 16'h0510, 16'h0, 0, 2'b11, 1, 2, 1, "R5 async late");
        access(1, 16'h0614, 16'hCAFE, 0, 2'b00, 6, 0, 1, "R5 async early");
        // R6: zero wait ignores missing acknowledge
        access(0, 16'h0718, 16'h0, 0, 2'b01, 0, -1, 0, "R6 zero wait");
        access(1, 16'h081C, 16'h5555, 0, 2'b10, 0, -1, 1, "R6 zero wait async");
        // R7: DRAM-type ignores missing acknowledge
        access(0, 16'h0920, 16'h0, 1, 2'b01, 3, -1, 0, "R7 dram");
        // R9: other polarity
        cfg_attr_pol = 2'b10;
        access(1, 16'h0A24, 16'h7777, 0, 2'b11, 1, 0, 0, "R9 pol len");
        // R8: acknowledge pulsed while idle
        force_ack = 1;
        repeat (4) @(negedge clk);
        force_ack = 0;
        repeat (2) @(negedge clk);
        access(0, 16'h0B28, 16'h0, 0, 2'b01, 2, 4, 0, "R8 idle ack ignored");

        // R12: standby blocks a new request
        @(negedge clk);
        standby = 1'b1;
        cfg_min_wait = 4'd1; cfg_ack_async = 0; core_we = 0; core_dram = 0;
        core_addr = 16'h0C2C; core_attr_sel = 2'b01; ack_at = 0;
        begin
            exp_t e;
            e.we = 0; e.addr = 16'h0C2C; e.data = 0;
            e.attr = attr_exp(2'b01, cfg_attr_pol); e.len = 2; e.tag = "R12 after standby";
            q.push_back(e);
        end
        core_req = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk(bus_rd_n && !bus_ctl_oe, "R12 held in standby", {bus_rd_n, bus_ctl_oe}, 2'b10);
        end
        standby = 1'b0;
        while (!core_ready) @(negedge clk);
        core_req = 1'b0;
        ack_at = -1;
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R10 all completions seen", q.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule